// File: doc/BRIEF.md
# Two-Channel Load-Line Setting Register with Write Validation

This block keeps one 16-bit load-line (droop) setting for each of two output channels. Transactions arrive already decoded from the management bus as a single-cycle completion strobe. Each strobe carries a command code, the current page value, a direction bit, a size bit that marks a word-sized access, and a 16-bit data word. The block answers only its own command code. Each stored word is driven continuously on a per-channel output, where downstream regulation logic can use it.

A write is accepted only when the data word is a member of a fixed set of legal codes for the channel it targets. Channel B accepts a smaller set than channel A. A write to both channels at once succeeds only when the word is legal for both. A rejected write, a non-word access or an unknown page leaves both settings unchanged. In that case the block sets a sticky communication-fault flag, the matching summary bit in the status word, and an active-low alert. All of these stay set until a clear-faults pulse arrives. On reset, each channel loads its mantissa from a reset-value input, which stands in for non-volatile storage.

Top module: `droop_setting_bank`

## Requirements
- R1: After synchronous reset, set_a is {11010b, rst_mant_a} and set_b is {11010b, rst_mant_b}. cml_status and status_word are zero, alert_n is 1 and rd_valid is 0.
- R2: Bits 15:11 of every stored word read 11010b. An accepted write stores the full data word, and the setting output changes on the rising edge where txn_done is sampled high, never on any other edge.
- R3: Command code 28h selects this register. Page 00h addresses channel A, page 01h addresses channel B, and page FFh addresses both channels.
- R4: Channel A accepts exactly the 64 words D0xxh whose low byte is one of the following. Single values 00, 08, 10, 14, 18, 1C, 20, 24, 28, 30. Runs 33–3F and 40–44. Multiples of 8 from 48 to 98, plus 7C, 84 and 8C. The run 9B–AC. Single values B0, B8, C0, C8. Any other word, including one with a different exponent or with nonzero mantissa bits 10:8, is illegal.
- R5: Channel B accepts only those channel-A codes whose low byte is at most 38h, which gives 16 codes from D000h to D038h.
- R6: A write of an illegal word leaves the stored value unchanged. It sets cml_status bit 6 (invalid data) and status_word bit 1 (communication summary), and drives alert_n low.
- R7: A page-FFh write updates both channels only when the word is legal for both. Otherwise neither channel changes and the R6 fault is raised.
- R8: An access to command 28h that is not word-sized, or that carries a page other than 00h, 01h or FFh, changes no setting and produces no read response. It sets cml_status bit 7 (invalid access), sets status_word bit 1 and drives alert_n low.
- R9: A valid word read gives rd_valid high for exactly one cycle, on the edge after the strobe. rd_data is the addressed channel's stored word, and page FFh reads channel A.
- R10: Transactions that carry any other command code have no effect on the settings, the flags or the alert.
- R11: clear_faults zeroes cml_status and status_word and releases alert_n on the next edge. A fault raised in the same cycle as clear_faults remains set.
- R12: Fault flags are sticky: later accepted transactions do not clear them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_done | input | 1 | One-cycle strobe: a decoded transaction is complete |
| txn_cmd | input | 8 | Command code of the transaction |
| txn_page | input | 8 | Current page value |
| txn_write | input | 1 | 1 = write, 0 = read |
| txn_word | input | 1 | 1 = word-sized access |
| txn_wdata | input | 16 | Write data word |
| rst_mant_a | input | 11 | Reset mantissa for channel A |
| rst_mant_b | input | 11 | Reset mantissa for channel B |
| clear_faults | input | 1 | One-cycle clear of fault flags and alert |
| rd_data | output | 16 | Read response word |
| rd_valid | output | 1 | Read response valid pulse |
| set_a | output | 16 | Stored setting, channel A |
| set_b | output | 16 | Stored setting, channel B |
| cml_status | output | 8 | Communication status byte (bit 7 access, bit 6 data) |
| status_word | output | 16 | Summary status word (bit 1 communication) |
| alert_n | output | 1 | Active-low alert |

## Verification
The fault-clear path and the fault-set path can act in the same cycle: a host may clear faults just as a new rejected transaction completes. The bench drives clear_faults together with an illegal channel-B write, and again together with an unknown-page access. In the cycle after, it requires that the new flag is present, that the older flag is gone, and that alert_n stays low. A further lone clear must then release everything.

// File: rtl/droop_pkg.sv
package droop_pkg;
  localparam int WORD_W = 16;
  localparam int MANT_W = 11;
  localparam int EXP_W  = WORD_W - MANT_W;
  localparam int NCH    = 2;
  localparam logic [EXP_W-1:0] EXP_FIXED = 5'b11010;

  // membership of the mantissa low byte in the channel-A code set
  function automatic logic code_listed(input logic [7:0] m);
    logic hit;
    hit = 1'b0;
    if (m inside {8'h00, 8'h08, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20,
                  8'h24, 8'h28, 8'h30})            hit = 1'b1;
    if (m >= 8'h33 && m <= 8'h44)                  hit = 1'b1;
    if (m >= 8'h48 && m <= 8'h98 && m[2:0] == 3'd0) hit = 1'b1;
    if (m inside {8'h7C, 8'h84, 8'h8C})            hit = 1'b1;
    if (m >= 8'h9B && m <= 8'hAC)                  hit = 1'b1;
    if (m inside {8'hB0, 8'hB8, 8'hC0, 8'hC8})     hit = 1'b1;
    return hit;
  endfunction
endpackage

// File: rtl/droop_code_check.sv
module droop_code_check
  import droop_pkg::*;
#(
  parameter logic [MANT_W-1:0] MANT_LIMIT = 11'h0C8
) (
  input  logic [WORD_W-1:0] word,
  output logic              legal
);
  logic exp_ok, high_zero, in_set, in_range;

  always_comb begin
    exp_ok    = (word[WORD_W-1:MANT_W] == EXP_FIXED);
    high_zero = (word[MANT_W-1:8] == '0);
    in_set    = code_listed(word[7:0]);
    in_range  = (word[MANT_W-1:0] <= MANT_LIMIT);
    legal     = exp_ok && high_zero && in_set && in_range;
  end
endmodule

// File: rtl/droop_chan_reg.sv
module droop_chan_reg
  import droop_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [MANT_W-1:0] rst_mant,
  input  logic              we,
  input  logic [MANT_W-1:0] wr_mant,
  output logic [WORD_W-1:0] setting
);
  logic [MANT_W-1:0] mant_q;

  always_ff @(posedge clk) begin
    if (rst)     mant_q <= rst_mant;
    else if (we) mant_q <= wr_mant;
  end

  assign setting = {EXP_FIXED, mant_q};
endmodule

// File: rtl/droop_fault_status.sv
module droop_fault_status #(
  parameter int CML_ACC_BIT  = 7,
  parameter int CML_DATA_BIT = 6,
  parameter int SW_CML_BIT   = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        set_acc,
  input  logic        set_data,
  output logic [7:0]  cml_status,
  output logic [15:0] status_word,
  output logic        alert_n
);
  logic acc_q, data_q, acc_d, data_d;

  always_comb begin
    acc_d  = (acc_q  && !clr) || set_acc;
    data_d = (data_q && !clr) || set_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= 1'b0;
      data_q  <= 1'b0;
      alert_n <= 1'b1;
    end else begin
      acc_q   <= acc_d;
      data_q  <= data_d;
      alert_n <= !(acc_d || data_d);
    end
  end

  always_comb begin
    cml_status               = '0;
    cml_status[CML_ACC_BIT]  = acc_q;
    cml_status[CML_DATA_BIT] = data_q;
    status_word              = '0;
    status_word[SW_CML_BIT]  = acc_q || data_q;
  end
endmodule

// File: rtl/droop_setting_bank.sv
module droop_setting_bank
  import droop_pkg::*;
#(
  parameter logic [7:0]        CMD_CODE = 8'h28,
  parameter logic [7:0]        PAGE_A   = 8'h00,
  parameter logic [7:0]        PAGE_B   = 8'h01,
  parameter logic [7:0]        PAGE_ALL = 8'hFF,
  parameter logic [MANT_W-1:0] LIM_A    = 11'h0C8,
  parameter logic [MANT_W-1:0] LIM_B    = 11'h038
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              txn_done,
  input  logic [7:0]        txn_cmd,
  input  logic [7:0]        txn_page,
  input  logic              txn_write,
  input  logic              txn_word,
  input  logic [WORD_W-1:0] txn_wdata,
  input  logic [MANT_W-1:0] rst_mant_a,
  input  logic [MANT_W-1:0] rst_mant_b,
  input  logic              clear_faults,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [WORD_W-1:0] set_a,
  output logic [WORD_W-1:0] set_b,
  output logic [7:0]        cml_status,
  output logic [15:0]       status_word,
  output logic              alert_n
);
  logic hit, page_all, page_ok, is_wr, is_rd, acc_bad, data_ok;
  logic [NCH-1:0] page_one, tgt, legal, we;
  logic [MANT_W-1:0] rst_mant [NCH];
  logic [WORD_W-1:0] chan_set [NCH];

  assign rst_mant[0] = rst_mant_a;
  assign rst_mant[1] = rst_mant_b;

  always_comb begin
    hit      = txn_done && (txn_cmd == CMD_CODE);
    page_all = (txn_page == PAGE_ALL);
    page_ok  = page_all || (|page_one);
    is_wr    = hit && txn_write && txn_word && page_ok;
    is_rd    = hit && !txn_write && txn_word && page_ok;
    acc_bad  = hit && !(txn_word && page_ok);
    data_ok  = &(~tgt | legal);
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    localparam logic [7:0]        MY_PAGE  = (g == 0) ? PAGE_A : PAGE_B;
    localparam logic [MANT_W-1:0] MY_LIMIT = (g == 0) ? LIM_A : LIM_B;

    assign page_one[g] = (txn_page == MY_PAGE);
    assign tgt[g]      = page_one[g] || page_all;
    assign we[g]       = is_wr && data_ok && tgt[g];

    droop_code_check #(.MANT_LIMIT(MY_LIMIT)) chk_u (
      .word  (txn_wdata),
      .legal (legal[g])
    );

    droop_chan_reg reg_u (
      .clk      (clk),
      .rst      (rst),
      .rst_mant (rst_mant[g]),
      .we       (we[g]),
      .wr_mant  (txn_wdata[MANT_W-1:0]),
      .setting  (chan_set[g])
    );
  end

  assign set_a = chan_set[0];
  assign set_b = chan_set[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= is_rd;
      if (is_rd) rd_data <= page_one[1] ? chan_set[1] : chan_set[0];
    end
  end

  droop_fault_status fault_u (
    .clk         (clk),
    .rst         (rst),
    .clr         (clear_faults),
    .set_acc     (acc_bad),
    .set_data    (is_wr && !data_ok),
    .cml_status  (cml_status),
    .status_word (status_word),
    .alert_n     (alert_n)
  );
endmodule

// File: rtl/droop_setting_bank_chk.sv
module droop_setting_bank_chk (
  input logic        clk,
  input logic        rst,
  input logic        txn_done,
  input logic [7:0]  txn_cmd,
  input logic [7:0]  txn_page,
  input logic        txn_write,
  input logic        txn_word,
  input logic [15:0] txn_wdata,
  input logic        clear_faults,
  input logic        rd_valid,
  input logic [15:0] set_a,
  input logic [15:0] set_b,
  input logic [7:0]  cml_status,
  input logic [15:0] status_word,
  input logic        alert_n
);
  logic own;
  assign own = txn_done && (txn_cmd == 8'h28);

  // R2: settings move only on an edge that samples a write strobe
  p_hold_a_r2: assert property (@(posedge clk) disable iff (rst)
    !(own && txn_write) |=> $stable(set_a));
  p_hold_b_r2: assert property (@(posedge clk) disable iff (rst)
    !(own && txn_write) |=> $stable(set_b));

  // R5: a channel-B write above D038h is refused and flagged
  p_b_limit_r5: assert property (@(posedge clk) disable iff (rst)
    (own && txn_write && txn_word && txn_page == 8'h01 && txn_wdata > 16'hD038)
    |=> ($stable(set_b) && cml_status[6]));

  // R8: unknown page flags an access fault and updates nothing
  p_bad_page_r8: assert property (@(posedge clk) disable iff (rst)
    (own && !(txn_page inside {8'h00, 8'h01, 8'hFF}))
    |=> (cml_status[7] && !rd_valid && $stable(set_a) && $stable(set_b)));

  // R11: a lone clear empties the flags and releases the alert
  p_clear_r11: assert property (@(posedge clk) disable iff (rst)
    (clear_faults && !txn_done) |=> (cml_status == 8'h00 && alert_n));

  // R6: summary bit and alert track the communication flags
  p_summary_r6: assert property (@(posedge clk) disable iff (rst)
    (status_word[1] == (|cml_status)) && (alert_n == !(|cml_status)));
endmodule

bind droop_setting_bank droop_setting_bank_chk chk_i (
  .clk          (clk),
  .rst          (rst),
  .txn_done     (txn_done),
  .txn_cmd      (txn_cmd),
  .txn_page     (txn_page),
  .txn_write    (txn_write),
  .txn_word     (txn_word),
  .txn_wdata    (txn_wdata),
  .clear_faults (clear_faults),
  .rd_valid     (rd_valid),
  .set_a        (set_a),
  .set_b        (set_b),
  .cml_status   (cml_status),
  .status_word  (status_word),
  .alert_n      (alert_n)
);

// File: tb/droop_setting_bank_tb.sv
module droop_setting_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        txn_done = 1'b0;
  logic [7:0]  txn_cmd = 8'h00;
  logic [7:0]  txn_page = 8'h00;
  logic        txn_write = 1'b0;
  logic        txn_word = 1'b1;
  logic [15:0] txn_wdata = 16'h0000;
  logic [10:0] rst_mant_a = 11'h024;
  logic [10:0] rst_mant_b = 11'h710;
  logic        clear_faults = 1'b0;
  logic [15:0] rd_data, set_a, set_b, status_word;
  logic        rd_valid, alert_n;
  logic [7:0]  cml_status;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  droop_setting_bank dut_i (
    .clk(clk), .rst(rst), .txn_done(txn_done), .txn_cmd(txn_cmd),
    .txn_page(txn_page), .txn_write(txn_write), .txn_word(txn_word),
    .txn_wdata(txn_wdata), .rst_mant_a(rst_mant_a), .rst_mant_b(rst_mant_b),
    .clear_faults(clear_faults), .rd_data(rd_data), .rd_valid(rd_valid),
    .set_a(set_a), .set_b(set_b), .cml_status(cml_status),
    .status_word(status_word), .alert_n(alert_n)
  );

  function automatic bit ref_a_ok(input logic [15:0] w);
    logic [7:0] m;
    m = w[7:0];
    if (w[15:8] != 8'hD0) return 0;
    case (m)
      8'h00, 8'h08, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h24, 8'h28, 8'h30,
      8'h48, 8'h50, 8'h58, 8'h60, 8'h68, 8'h70, 8'h78, 8'h7C, 8'h80, 8'h84,
      8'h88, 8'h8C, 8'h90, 8'h98, 8'hB0, 8'hB8, 8'hC0, 8'hC8: return 1;
      default: return ((m >= 8'h33 && m <= 8'h44) || (m >= 8'h9B && m <= 8'hAC));
    endcase
  endfunction

  function automatic bit ref_b_ok(input logic [15:0] w);
    return ref_a_ok(w) && (w[7:0] <= 8'h38);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic txn(input logic [7:0] cmd, input logic [7:0] page,
                     input bit wr, input bit word, input logic [15:0] d,
                     input bit clr);
    @(negedge clk);
    txn_done = 1'b1; txn_cmd = cmd; txn_page = page; txn_write = wr;
    txn_word = word; txn_wdata = d; clear_faults = clr;
    @(negedge clk);
    txn_done = 1'b0; clear_faults = 1'b0;
  endtask

  task automatic clr_only();
    @(negedge clk); clear_faults = 1'b1;
    @(negedge clk); clear_faults = 1'b0;
    chk(cml_status == 0 && alert_n, "R11 clear", {8'h0, cml_status}, 16'h0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(set_a == 16'hD024, "R1 set_a", set_a, 16'hD024);
    chk(set_b == 16'hD710, "R1 set_b", set_b, 16'hD710);
    chk(cml_status == 0 && status_word == 0 && alert_n && !rd_valid,
        "R1 status", status_word, 16'h0);
  endtask

  task automatic t_legal();
    txn(8'h28, 8'h00, 1, 1, 16'hD0A5, 0);
    chk(set_a == 16'hD0A5, "R2 R4 write A", set_a, 16'hD0A5);
    chk(set_b == 16'hD710, "R3 page 00 leaves B", set_b, 16'hD710);
    txn(8'h28, 8'h01, 1, 1, 16'hD014, 0);
    chk(set_b == 16'hD014, "R3 write B", set_b, 16'hD014);
    chk(set_a == 16'hD0A5 && alert_n, "R3 page 01 leaves A", set_a, 16'hD0A5);
  endtask

  task automatic t_b_limit();
    txn(8'h28, 8'h01, 1, 1, 16'hD039, 0);
    chk(set_b == 16'hD014, "R5 D039 refused on B", set_b, 16'hD014);
    chk(cml_status == 8'h40, "R6 data flag", {8'h0, cml_status}, 16'h0040);
    chk(status_word == 16'h0002 && !alert_n, "R6 summary/alert", status_word, 16'h0002);
    txn(8'h28, 8'h01, 1, 1, 16'hD038, 0);
    chk(set_b == 16'hD038, "R5 D038 accepted on B", set_b, 16'hD038);
    chk(cml_status == 8'h40 && !alert_n, "R12 sticky", {8'h0, cml_status}, 16'h0040);
    clr_only();
  endtask

  task automatic t_page_all();
    txn(8'h28, 8'hFF, 1, 1, 16'hD01C, 0);
    chk(set_a == 16'hD01C && set_b == 16'hD01C, "R7 FF both", set_a, 16'hD01C);
    chk(alert_n, "R7 FF legal no alert", {15'h0, alert_n}, 16'h1);
    txn(8'h28, 8'hFF, 1, 1, 16'hD050, 0);
    chk(set_a == 16'hD01C && set_b == 16'hD01C, "R7 FF illegal for B", set_a, 16'hD01C);
    chk(cml_status == 8'h40 && !alert_n, "R7 FF fault", {8'h0, cml_status}, 16'h0040);
    clr_only();
  endtask

  task automatic t_bad_access();
    txn(8'h28, 8'h02, 1, 1, 16'hD008, 0);
    chk(set_a == 16'hD01C && set_b == 16'hD01C, "R8 page 02 no update", set_a, 16'hD01C);
    chk(cml_status == 8'h80 && !alert_n, "R8 page flag", {8'h0, cml_status}, 16'h0080);
    clr_only();
    txn(8'h28, 8'h00, 1, 0, 16'hD008, 0);
    chk(set_a == 16'hD01C, "R8 byte write", set_a, 16'hD01C);
    chk(cml_status == 8'h80 && status_word == 16'h2, "R8 byte flag", {8'h0, cml_status}, 16'h0080);
    clr_only();
    txn(8'h28, 8'h05, 0, 1, 16'h0000, 0);
    chk(!rd_valid && cml_status == 8'h80, "R8 bad read", {8'h0, cml_status}, 16'h0080);
    clr_only();
  endtask

  task automatic t_read();
    txn(8'h28, 8'h00, 1, 1, 16'hD0C8, 0);
    txn(8'h28, 8'h01, 1, 1, 16'hD030, 0);
    txn(8'h28, 8'h01, 0, 1, 16'h0000, 0);
    chk(rd_valid && rd_data == 16'hD030, "R9 read B", rd_data, 16'hD030);
    @(negedge clk);
    chk(!rd_valid, "R9 single pulse", {15'h0, rd_valid}, 16'h0);
    txn(8'h28, 8'hFF, 0, 1, 16'h0000, 0);
    chk(rd_valid && rd_data == 16'hD0C8, "R9 FF reads A", rd_data, 16'hD0C8);
    txn(8'h28, 8'h00, 0, 1, 16'h0000, 0);
    chk(rd_data[15:11] == 5'b11010 && rd_data == 16'hD0C8, "R2 exponent", rd_data, 16'hD0C8);
  endtask

  task automatic t_other_cmd();
    txn(8'h29, 8'h00, 1, 1, 16'hD008, 0);
    chk(set_a == 16'hD0C8, "R10 foreign write", set_a, 16'hD0C8);
    txn(8'h27, 8'h01, 1, 1, 16'hD0FF, 0);
    txn(8'h29, 8'h07, 1, 0, 16'h1234, 0);
    chk(set_b == 16'hD030 && cml_status == 0 && alert_n, "R10 no fault",
        {8'h0, cml_status}, 16'h0);
    txn(8'h29, 8'h00, 0, 1, 16'h0000, 0);
    chk(!rd_valid, "R10 no read", {15'h0, rd_valid}, 16'h0);
  endtask

  task automatic t_collision();
    txn(8'h28, 8'h02, 1, 1, 16'hD000, 0);
    txn(8'h28, 8'h01, 1, 1, 16'hD040, 1);
    chk(cml_status == 8'h40 && !alert_n, "R11 set wins over clear",
        {8'h0, cml_status}, 16'h0040);
    txn(8'h28, 8'h09, 1, 1, 16'hD000, 1);
    chk(cml_status == 8'h80 && !alert_n, "R11 clear with page fault",
        {8'h0, cml_status}, 16'h0080);
    clr_only();
  endtask

  task automatic t_sweep();
    logic [15:0] ea, eb;
    int bad_a = 0, bad_b = 0;
    ea = set_a; eb = set_b;
    for (int m = 0; m < 256; m++) begin
      logic [15:0] w;
      w = {8'hD0, 8'(m)};
      txn(8'h28, 8'h00, 1, 1, w, 0);
      if (ref_a_ok(w)) ea = w;
      if (set_a != ea) begin bad_a++; chk(0, "R4 sweep A", set_a, ea); end
      txn(8'h28, 8'h01, 1, 1, w, 0);
      if (ref_b_ok(w)) eb = w;
      if (set_b != eb) begin bad_b++; chk(0, "R5 sweep B", set_b, eb); end
    end
    chk(bad_a == 0, "R4 sweep A total", 16'(bad_a), 16'h0);
    chk(bad_b == 0, "R5 sweep B total", 16'(bad_b), 16'h0);
    clr_only();
    txn(8'h28, 8'h00, 1, 1, 16'hC808, 0);
    chk(set_a == ea && cml_status == 8'h40, "R4 wrong exponent", set_a, ea);
    clr_only();
    txn(8'h28, 8'h00, 1, 1, 16'hD108, 0);
    chk(set_a == ea && cml_status == 8'h40, "R4 mantissa bit 8", set_a, ea);
    clr_only();
  endtask

  initial begin
    t_reset();
    t_legal();
    t_b_limit();
    t_page_all();
    t_bad_access();
    t_read();
    t_other_cmd();
    t_collision();
    t_sweep();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h1, 16'h0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule